// File: doc/BRIEF.md
# Two-Step Current-Pulse Digitizer Controller

This block is the digital back end of one channel of a two-step current-pulse digitizer. A trigger marks the start of a current pulse. On a trigger the block strobes a first analog memory cell, which holds the output of a free-running integrator at the start of the window. It then opens a fixed integration window. When the window closes it strobes a second memory cell. While the window is open it keeps a signed tally of the coarse charge-pump events. Events from the upper comparator add one and events from the lower comparator subtract one.

The channel has two capture slots, each holding one sample pair and one tally. A new event can therefore open in the same cycle that the previous window closes, while the earlier pair still waits for conversion. A single shared 8-bit converter, driven through a start/done handshake, reads both cells of each slot in close order. The fine residue is the end sample minus the start sample, which cancels baseline drift of the integrator because the integrator is never reset. The block scales the tally by 256, adds the residue, and presents the saturated 14-bit signed result with a one-cycle valid strobe.

Top module: `pulse_digitizer`

## Requirements
- R1: After synchronous reset, every output is low or zero. This covers the strobes, the converter start, the valid strobe and the overflow flag.
- R2: A trigger sampled while no window is open and the next slot in rotation is free is accepted. `mc_first_o` is then high for exactly the following cycle, and `mc_first_slot_o` names that slot. Slots are handed out in rotation 0, 1, 0, and so on.
- R3: The window lasts W = CLK_HZ·WIN_NS/10⁹ cycles. `mc_second_o` pulses exactly W cycles after `mc_first_o`, and `mc_second_slot_o` names the same slot.
- R4: The tally covers the W sampled cycles starting with the trigger cycle. An up event alone adds 1, a down event alone subtracts 1, and both together or neither add 0. A pump event in the closing cycle is left out of the closing window.
- R5: A trigger sampled in the closing cycle is accepted when the next slot is free. The new window counts that cycle's pump event, and the two windows have no gap between them.
- R6: A trigger sampled while a window is open, other than in its closing cycle, is ignored. It produces no strobe and no overflow.
- R7: A trigger that would be accepted except that the next slot is still occupied produces a one-cycle `ovf_o` pulse and no `mc_first_o`. Stored data is left intact.
- R8: For each closed slot, taken in close order, the converter is started once with `adc_cell_o`=0, which selects the start sample. After that conversion's `adc_done_i`, it is started once with `adc_cell_o`=1, which selects the end sample. `adc_slot_o` names the slot, and `adc_done_i` has no effect while no conversion is pending.
- R9: The result equals tally·256 + (end − start), with the samples taken as unsigned 8-bit values. It is saturated to the range [−8192, 8191], and `code_valid_o` is high for one cycle, one cycle after the second done. Results appear in close order.
- R10: A slot becomes free in the cycle its result is presented. A trigger in the next cycle can then reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Pulse-start trigger |
| pump_up_i | input | 1 | Upper-threshold charge-pump event |
| pump_dn_i | input | 1 | Lower-threshold charge-pump event |
| mc_first_o | output | 1 | Start-sample memory-cell strobe |
| mc_first_slot_o | output | SLOT_W | Slot of the start-sample strobe |
| mc_second_o | output | 1 | End-sample memory-cell strobe |
| mc_second_slot_o | output | SLOT_W | Slot of the end-sample strobe |
| adc_start_o | output | 1 | Converter start pulse |
| adc_slot_o | output | SLOT_W | Slot whose cell is converted |
| adc_cell_o | output | 1 | 0 selects the start sample, 1 selects the end sample |
| adc_done_i | input | 1 | Converter done pulse |
| adc_data_i | input | ADC_W | Converter result, valid with done |
| code_o | output | OUT_W | Signed merged result |
| code_valid_o | output | 1 | One-cycle result strobe |
| ovf_o | output | 1 | Trigger dropped because all slots were occupied |

## Verification
Single isolated events are driven with pump tallies that are zero, small positive, mixed up/down (including cycles where both are high), and full-window in either direction. These separate a sign or scaling fault from a saturation fault. The integrator is modelled as a ramp, and varying its slope and offset yields residues of both signs and with wrap-around, which exposes operand order and sign extension of the difference. A trigger held high across several windows, with pump events at every boundary, tells apart correct boundary crediting and zero-deadtime re-arming from an off-by-one window. A slow converter under the same held trigger forces slot exhaustion and checks the overflow, the later reuse of the freed slots, and a mid-window retrigger that must be ignored.

// File: rtl/pdig_pkg.sv
package pdig_pkg;

  typedef enum logic [1:0] {
    CV_IDLE   = 2'd0,
    CV_FIRST  = 2'd1,
    CV_SECOND = 2'd2
  } conv_state_t;

  // Signed tally step from the two pump comparators.
  function automatic logic signed [1:0] pump_step(input logic up, input logic dn);
    if (up && !dn)      return 2'sb01;
    else if (dn && !up) return 2'sb11;
    else                return 2'sb00;
  endfunction

endpackage

// File: rtl/pdig_window.sv
module pdig_window
  import pdig_pkg::*;
#(
  parameter int W      = 100,
  parameter int NSLOT  = 2,
  parameter int SLOT_W = 1,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  input  logic                    rel_i,
  input  logic [SLOT_W-1:0]       rel_slot_i,
  input  logic [SLOT_W-1:0]       rd_slot_i,
  output logic [NSLOT-1:0]        closed_o,
  output logic signed [CNT_W-1:0] rd_count_o,
  output logic                    mc_first_o,
  output logic [SLOT_W-1:0]       mc_first_slot_o,
  output logic                    mc_second_o,
  output logic [SLOT_W-1:0]       mc_second_slot_o,
  output logic                    ovf_o
);

  localparam int WC_W = $clog2(W + 1);

  logic                    active;
  logic [WC_W-1:0]         wcnt;
  logic signed [CNT_W-1:0] acc;
  logic [SLOT_W-1:0]       wp, wp_nxt, cur;
  logic [NSLOT-1:0]        busy, closed;
  logic signed [CNT_W-1:0] cnt_mem [NSLOT];
  logic signed [1:0]       step;
  logic signed [CNT_W-1:0] step_ext;
  logic                    closing, open_ok, accept;

  assign step     = pump_step(up_i, dn_i);
  assign step_ext = CNT_W'(step);
  assign closing  = active && (wcnt == WC_W'(W));
  assign open_ok  = !active || closing;
  assign accept   = trig_i && open_ok && !busy[wp];
  assign wp_nxt   = (wp == SLOT_W'(NSLOT - 1)) ? '0 : wp + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active           <= 1'b0;
      wcnt             <= '0;
      acc              <= '0;
      wp               <= '0;
      cur              <= '0;
      busy             <= '0;
      closed           <= '0;
      mc_first_o       <= 1'b0;
      mc_first_slot_o  <= '0;
      mc_second_o      <= 1'b0;
      mc_second_slot_o <= '0;
      ovf_o            <= 1'b0;
    end else begin
      mc_first_o  <= accept;
      mc_second_o <= closing;
      ovf_o       <= trig_i && open_ok && busy[wp];
      if (accept)  mc_first_slot_o  <= wp;
      if (closing) mc_second_slot_o <= cur;

      if (closing) begin
        active      <= 1'b0;
        closed[cur] <= 1'b1;
      end else if (active) begin
        acc  <= acc + step_ext;
        wcnt <= wcnt + 1'b1;
      end

      if (accept) begin
        active   <= 1'b1;
        wcnt     <= WC_W'(1);
        acc      <= step_ext;
        cur      <= wp;
        wp       <= wp_nxt;
        busy[wp] <= 1'b1;
      end

      if (rel_i) begin
        busy[rel_slot_i]   <= 1'b0;
        closed[rel_slot_i] <= 1'b0;
      end
    end
  end

  // Tally store per slot, written without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (closing) cnt_mem[cur] <= acc;
  end

  assign rd_count_o = cnt_mem[rd_slot_i];
  assign closed_o   = closed;

  // R2: a start strobe is never longer than one cycle
  a_r2_first_single: assert property (@(posedge clk) disable iff (rst)
    mc_first_o |=> !mc_first_o);

  // R7: a dropped trigger never also opens a window
  a_r7_ovf_excl: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> !mc_first_o);

  // R4: the tally never exceeds the window length in magnitude
  a_r4_acc_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(acc) <= W) && (int'(acc) >= -W));

  // R10: a released slot must have been occupied
  a_r10_rel_busy: assert property (@(posedge clk) disable iff (rst)
    rel_i |-> busy[rel_slot_i]);

endmodule

// File: rtl/pdig_convert.sv
module pdig_convert
  import pdig_pkg::*;
#(
  parameter int NSLOT  = 2,
  parameter int SLOT_W = 1,
  parameter int CNT_W  = 8,
  parameter int ADC_W  = 8,
  parameter int OUT_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        closed_i,
  output logic [SLOT_W-1:0]       rd_slot_o,
  input  logic signed [CNT_W-1:0] rd_count_i,
  output logic                    adc_start_o,
  output logic [SLOT_W-1:0]       adc_slot_o,
  output logic                    adc_cell_o,
  input  logic                    adc_done_i,
  input  logic [ADC_W-1:0]        adc_data_i,
  output logic [OUT_W-1:0]        code_o,
  output logic                    code_valid_o,
  output logic                    rel_o,
  output logic [SLOT_W-1:0]       rel_slot_o
);

  localparam int SUM_W = CNT_W + ADC_W + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(2 ** (OUT_W - 1));

  conv_state_t             st;
  logic [SLOT_W-1:0]       rp;
  logic [ADC_W-1:0]        s0;
  logic signed [ADC_W+1:0] diff;
  logic signed [SUM_W-1:0] sum;
  logic [OUT_W-1:0]        sat;
  logic                    finish;

  assign diff   = $signed({2'b00, adc_data_i}) - $signed({2'b00, s0});
  assign sum    = (SUM_W'(rd_count_i) <<< ADC_W) + SUM_W'(diff);
  assign sat    = (sum > MAXV) ? MAXV[OUT_W-1:0] :
                  (sum < MINV) ? MINV[OUT_W-1:0] : sum[OUT_W-1:0];
  assign finish = (st == CV_SECOND) && adc_done_i;

  assign rd_slot_o  = rp;
  assign rel_o      = finish;
  assign rel_slot_o = rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= CV_IDLE;
      rp           <= '0;
      s0           <= '0;
      adc_start_o  <= 1'b0;
      adc_slot_o   <= '0;
      adc_cell_o   <= 1'b0;
      code_o       <= '0;
      code_valid_o <= 1'b0;
    end else begin
      adc_start_o  <= 1'b0;
      code_valid_o <= 1'b0;
      case (st)
        CV_IDLE: if (closed_i[rp]) begin
          adc_start_o <= 1'b1;
          adc_slot_o  <= rp;
          adc_cell_o  <= 1'b0;
          st          <= CV_FIRST;
        end
        CV_FIRST: if (adc_done_i) begin
          s0          <= adc_data_i;
          adc_start_o <= 1'b1;
          adc_cell_o  <= 1'b1;
          st          <= CV_SECOND;
        end
        CV_SECOND: if (adc_done_i) begin
          code_o       <= sat;
          code_valid_o <= 1'b1;
          rp           <= (rp == SLOT_W'(NSLOT - 1)) ? '0 : rp + 1'b1;
          st           <= CV_IDLE;
        end
        default: st <= CV_IDLE;
      endcase
    end
  end

  // R8: each conversion start is a single-cycle pulse
  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |=> !adc_start_o);

  // R8: the end-sample conversion follows a completed start-sample conversion
  a_r8_second_after_done: assert property (@(posedge clk) disable iff (rst)
    (adc_start_o && adc_cell_o) |-> $past(adc_done_i));

  // R9: a result strobe lasts one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
    code_valid_o |=> !code_valid_o);

  // R9: a result follows the end-sample done
  a_r9_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    code_valid_o |-> $past(adc_done_i));

endmodule

// File: rtl/pulse_digitizer.sv
module pulse_digitizer #(
  parameter int CLK_HZ = 100_000_000,
  parameter int WIN_NS = 1000,
  parameter int NSLOT  = 2,
  parameter int CNT_W  = 8,
  parameter int ADC_W  = 8,
  parameter int OUT_W  = 14,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              pump_up_i,
  input  logic              pump_dn_i,
  output logic              mc_first_o,
  output logic [SLOT_W-1:0] mc_first_slot_o,
  output logic              mc_second_o,
  output logic [SLOT_W-1:0] mc_second_slot_o,
  output logic              adc_start_o,
  output logic [SLOT_W-1:0] adc_slot_o,
  output logic              adc_cell_o,
  input  logic              adc_done_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic [OUT_W-1:0]  code_o,
  output logic              code_valid_o,
  output logic              ovf_o
);

  localparam longint WIN_L = (longint'(CLK_HZ) * longint'(WIN_NS)) / 64'd1_000_000_000;
  localparam int W = int'(WIN_L);

  logic [NSLOT-1:0]        closed;
  logic [SLOT_W-1:0]       rd_slot, rel_slot;
  logic signed [CNT_W-1:0] rd_count;
  logic                    rel;

  pdig_window #(.W(W), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_win (
    .clk              (clk),
    .rst              (rst),
    .trig_i           (trig_i),
    .up_i             (pump_up_i),
    .dn_i             (pump_dn_i),
    .rel_i            (rel),
    .rel_slot_i       (rel_slot),
    .rd_slot_i        (rd_slot),
    .closed_o         (closed),
    .rd_count_o       (rd_count),
    .mc_first_o       (mc_first_o),
    .mc_first_slot_o  (mc_first_slot_o),
    .mc_second_o      (mc_second_o),
    .mc_second_slot_o (mc_second_slot_o),
    .ovf_o            (ovf_o)
  );

  pdig_convert #(.NSLOT(NSLOT), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                 .ADC_W(ADC_W), .OUT_W(OUT_W)) u_conv (
    .clk          (clk),
    .rst          (rst),
    .closed_i     (closed),
    .rd_slot_o    (rd_slot),
    .rd_count_i   (rd_count),
    .adc_start_o  (adc_start_o),
    .adc_slot_o   (adc_slot_o),
    .adc_cell_o   (adc_cell_o),
    .adc_done_i   (adc_done_i),
    .adc_data_i   (adc_data_i),
    .code_o       (code_o),
    .code_valid_o (code_valid_o),
    .rel_o        (rel),
    .rel_slot_o   (rel_slot)
  );

  // R3/R5: start and end strobes in one cycle always belong to different slots
  a_r5_distinct_slots: assert property (@(posedge clk) disable iff (rst)
    (mc_first_o && mc_second_o) |-> (mc_first_slot_o != mc_second_slot_o));

  // R8: the converter never starts while a result is being presented
  a_r8_no_start_on_valid: assert property (@(posedge clk) disable iff (rst)
    code_valid_o |-> !adc_start_o);

endmodule

// File: tb/pulse_digitizer_tb.sv
module pulse_digitizer_tb;

  localparam int CLK_HZ = 50_000_000;
  localparam int WIN_NS = 1000;
  localparam int W      = 50;
  localparam int NSLOT  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0, up = 1'b0, dn = 1'b0;
  logic       mc_first_o, mc_second_o, adc_start_o, adc_cell_o, code_valid_o, ovf_o;
  logic [0:0] mc_first_slot_o, mc_second_slot_o, adc_slot_o;
  logic       adc_done_i = 1'b0;
  logic [7:0] adc_data_i = '0;
  logic [13:0] code_o;

  always #10 clk = ~clk;

  pulse_digitizer #(.CLK_HZ(CLK_HZ), .WIN_NS(WIN_NS), .NSLOT(NSLOT)) u_dut (
    .clk(clk), .rst(rst), .trig_i(trig), .pump_up_i(up), .pump_dn_i(dn),
    .mc_first_o(mc_first_o), .mc_first_slot_o(mc_first_slot_o),
    .mc_second_o(mc_second_o), .mc_second_slot_o(mc_second_slot_o),
    .adc_start_o(adc_start_o), .adc_slot_o(adc_slot_o), .adc_cell_o(adc_cell_o),
    .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .code_o(code_o), .code_valid_o(code_valid_o), .ovf_o(ovf_o));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Integrator model: a ramp in cycle number, read as 8-bit.
  int base = 0, slope = 1, cyc = 0;
  function automatic int vin_at(input int n);
    return (base + n * slope) & 255;
  endfunction

  // Reference model state
  bit model_open = 0;
  int m_wc = 0, m_acc = 0, m_cur = 0, m_wp = 0, m_used = 0;
  int m_vs [NSLOT];
  int exp_codes [$];
  int conv_q [$];
  bit e_first = 0, e_second = 0, e_ovf = 0;
  int e_fslot = 0, e_sslot = 0;
  bit seen_valid = 0;
  int n_ovf = 0, n_codes = 0, n_pushed = 0, n_first = 0;

  function automatic int sat14(input int v);
    if (v > 8191)  return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      model_open = 0; m_wc = 0; m_acc = 0; m_cur = 0; m_wp = 0; m_used = 0;
      e_first = 0; e_second = 0; e_ovf = 0; cyc = 0;
    end else begin
      bit was_open, closing;
      int step;
      cyc++;
      if (seen_valid) m_used--;
      step = (up && !dn) ? 1 : (dn && !up) ? -1 : 0;
      was_open = model_open;
      closing  = model_open && (m_wc == W);
      e_first = 0; e_second = 0; e_ovf = 0;
      if (closing) begin
        e_second = 1; e_sslot = m_cur; model_open = 0;
        exp_codes.push_back(sat14(m_acc * 256 + vin_at(cyc) - m_vs[m_cur]));
        conv_q.push_back(m_cur);
        n_pushed++;
      end else if (model_open) begin
        m_acc += step; m_wc++;
      end
      if (trig && (!was_open || closing)) begin
        if (m_used < NSLOT) begin
          e_first = 1; e_fslot = m_wp; m_cur = m_wp; m_vs[m_wp] = vin_at(cyc);
          m_wp = (m_wp + 1) % NSLOT; m_used++;
          model_open = 1; m_wc = 1; m_acc = step;
        end else e_ovf = 1;
      end
    end
  end

  // Analog cells and converter model
  int cells [NSLOT][2];
  int adc_lat = 4, lat_cnt = 0, a_slot = 0, a_cell = 0, exp_cell = 0;
  bit adc_busy = 0;

  always @(negedge clk) begin
    adc_done_i <= 1'b0;
    if (!rst) begin
      if (mc_first_o)  cells[mc_first_slot_o][0] = vin_at(cyc);
      if (mc_second_o) cells[mc_second_slot_o][1] = vin_at(cyc);
      // R2, R5, R6: start strobes against the model every cycle
      chk(mc_first_o == e_first, "R2 first strobe", mc_first_o, e_first);
      if (e_first) chk(mc_first_slot_o == e_fslot, "R2 first slot", mc_first_slot_o, e_fslot);
      // R3: end strobe W cycles later on the same slot
      chk(mc_second_o == e_second, "R3 second strobe", mc_second_o, e_second);
      if (e_second) chk(mc_second_slot_o == e_sslot, "R3 second slot", mc_second_slot_o, e_sslot);
      // R7: overflow
      chk(ovf_o == e_ovf, "R7 overflow", ovf_o, e_ovf);
      if (mc_first_o) n_first++;
      if (ovf_o) n_ovf++;
      // R8: start order and cell selection
      if (adc_start_o) begin
        chk(adc_cell_o == exp_cell, "R8 cell order", adc_cell_o, exp_cell);
        if (conv_q.size() > 0)
          chk(adc_slot_o == conv_q[0], "R8 slot order", adc_slot_o, conv_q[0]);
        else chk(0, "R8 unexpected start", 1, 0);
        if (exp_cell == 1 && conv_q.size() > 0) void'(conv_q.pop_front());
        exp_cell = 1 - exp_cell;
        a_slot = adc_slot_o; a_cell = adc_cell_o; lat_cnt = adc_lat; adc_busy = 1;
      end else if (adc_busy) begin
        lat_cnt--;
        if (lat_cnt <= 0) begin
          adc_done_i <= 1'b1;
          adc_data_i <= 8'(cells[a_slot][a_cell]);
          adc_busy = 0;
        end
      end
      // R4, R9: merged result in close order
      if (code_valid_o) begin
        n_codes++;
        if (exp_codes.size() > 0) begin
          int e;
          e = exp_codes.pop_front();
          chk($signed(code_o) == e, "R9/R4 result", $signed(code_o), e);
        end else chk(0, "R9 unexpected result", $signed(code_o), 0);
      end
    end
    seen_valid = code_valid_o;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One event: trigger, then up events in the first nup cycles and down
  // events in the last ndn cycles of the window; optional mid-window retrigger (R6).
  task automatic event_win(input int nup, input int ndn, input bit retrig);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      trig = (i == 0) || (retrig && i == W / 2);
      up   = (i < nup);
      dn   = (i >= W - ndn);
    end
    @(negedge clk);
    trig = 0; up = 0; dn = 0;
    idle(60);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    chk(mc_first_o == 0 && mc_second_o == 0 && adc_start_o == 0, "R1 strobes", 1, 0);
    chk(code_valid_o == 0 && ovf_o == 0 && code_o == 0, "R1 result", int'(code_o), 0);
    rst = 0;
    idle(5);

    base = 7; slope = 1;  event_win(0, 0, 0);     // residue only
    base = 200; slope = 3; event_win(10, 0, 0);   // R4 positive tally
    base = 30; slope = -2; event_win(0, 17, 0);   // R4 negative tally, negative residue
    base = 90; slope = 5;  event_win(30, 30, 1);  // R4 overlap, R6 mid-window retrigger
    chk(n_ovf == 0, "R6 retrigger no overflow", n_ovf, 0);
    base = 0; slope = 1;   event_win(W, 0, 0);    // R9 positive saturation
    base = 255; slope = -1; event_win(0, W, 0);   // R9 negative saturation
    base = 11; slope = 7;  event_win(31, 0, 0);   // R9 just below the top of range

    // R5: held trigger, back-to-back windows, pumps every cycle
    n_first = 0;
    @(negedge clk); trig = 1; up = 1;
    idle(3 * W);
    @(negedge clk); trig = 0; up = 0;
    idle(80);
    chk(n_first >= 3, "R5 back-to-back windows", n_first, 3);

    // R7, R10: slow converter exhausts the slots, then a slot is reused
    adc_lat = 120; n_ovf = 0;
    @(negedge clk); trig = 1; dn = 1;
    idle(4 * W);
    @(negedge clk); trig = 0; dn = 0;
    chk(n_ovf > 0, "R7 overflow seen", n_ovf, 1);
    idle(700);
    adc_lat = 4; n_first = 0;
    base = 3; slope = 2; event_win(4, 2, 0);
    chk(n_first == 1, "R10 slot reused", n_first, 1);

    chk(exp_codes.size() == 0, "R9 all results delivered", exp_codes.size(), 0);
    chk(n_codes == n_pushed, "R10 one result per window", n_codes, n_pushed);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule